// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block runs ahead of an instruction consumer and keeps a small byte queue topped up with code. It holds a 16-bit code segment and a 16-bit instruction pointer, and forms each 20-bit physical fetch address by shifting the segment left by four bits and adding the pointer. Each fetch reads one byte through a simple request/response memory port. The returned byte goes into a first-in/first-out queue, and the pointer then steps to the next byte.

The consumer on the execution side takes bytes from the queue whenever it is ready. While the consumer is busy the unit keeps fetching until the queue is full. When the consumer redirects the flow with a jump, the unit empties the queue, throws away the reply to any fetch still in flight, and starts fetching again at the new segment and offset.

Top module: `pfq_unit`

## Requirements
- R1: On every cycle with `mem_req` high, `mem_addr` equals (segment × 16 + pointer) modulo 2^20.
- R2: After each issued fetch the pointer advances by one, so fetches without a jump between them ask for consecutive addresses.
- R3: Bytes leave on `q_byte` in the same order as their fetches were issued.
- R4: A byte that returns while the queue is empty is offered (`q_vld` high) in the next cycle, unless a jump is present in that cycle.
- R5: A new fetch is issued whenever no fetch is outstanding, no jump is present and `q_count` is below DEPTH (default 6). No fetch is issued while `q_count` equals DEPTH.
- R6: At most one fetch is outstanding. `mem_req` stays low from a request until its `mem_rvalid` has arrived, and a reply may take one cycle or more.
- R7: A cycle with `jmp_vld` high empties the queue (`q_count` is 0 and `q_vld` low afterwards). The new segment and offset are loaded, `q_vld` is low in the jump cycle itself, and a pop in that cycle has no effect.
- R8: The reply to a fetch issued before a jump is discarded, whether it arrives in the jump cycle or later. No fetch is issued until that reply has arrived.
- R9: `q_count` equals the number of bytes pushed minus bytes popped since the last jump or reset, and a push and a pop in the same cycle leave it unchanged.
- R10: A synchronous active-high reset empties the queue and loads the segment and pointer from RST_SEG and RST_IP. With the defaults, the first fetch after reset is at 20'hFFFF0.
- R11: The pointer wraps from 16'hFFFF to 0 within its segment, and the address sum drops any carry above bit 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| jmp_vld | input | 1 | Redirect fetching to a new segment:offset |
| jmp_seg | input | SEG_W (16) | New code segment for a jump |
| jmp_off | input | OFF_W (16) | New instruction pointer for a jump |
| mem_req | output | 1 | One-cycle fetch request |
| mem_addr | output | ADDR_W (20) | Physical byte address of the request |
| mem_rvalid | input | 1 | Reply data valid, at least one cycle after the request |
| mem_rdata | input | DATA_W (8) | Reply byte |
| q_pop | input | 1 | Consumer takes the head byte when `q_vld` is high |
| q_vld | output | 1 | Head byte available |
| q_byte | output | DATA_W (8) | Head byte of the queue |
| q_count | output | CNT_W (3) | Bytes currently held in the queue |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a reply being written into the queue while the consumer removes the head byte. The second is a jump arriving while a fetch is in flight, including the cycle in which its reply lands. A scoreboard drives random pop rates and memory latencies of one to four cycles, so that simultaneous push and pop happen often. It also forces jumps at the cycle a reply is due and at cycles while a reply is still pending. It then judges the run by the order of the popped bytes, by `q_count` against its own byte model, and by the address and the cycle of every request.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

   // fetch sequencer states
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // free to issue a fetch
      ST_WAIT = 2'd1,   // fetch outstanding, reply will be kept
      ST_DROP = 2'd2    // fetch outstanding, reply will be discarded
   } fetch_st_t;

endpackage

// File: rtl/pfq_addr.sv
module pfq_addr #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);

   localparam int SUM_W = ((SEG_W + SHIFT) > OFF_W ? (SEG_W + SHIFT) : OFF_W) + 1;

   generate
      if (ADDR_W <= SEG_W || ADDR_W < OFF_W) begin : g_bad_width
         $error("pfq_addr: ADDR_W must exceed SEG_W and cover OFF_W");
      end
   endgenerate

   logic [SUM_W-1:0] base_w;
   logic [SUM_W-1:0] sum_w;

   always_comb begin
      base_w = SUM_W'(seg) << SHIFT;
      sum_w  = base_w + SUM_W'(off);
      addr   = sum_w[ADDR_W-1:0];   // carry above the address width is dropped (R11)
   end

endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 6,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             flush,
   input  logic             push,
   input  logic [DW-1:0]    din,
   input  logic             pop,
   output logic [DW-1:0]    head,
   output logic             not_empty,
   output logic             full,
   output logic [CNT_W-1:0] count
);

   localparam bit POW2 = ((2 ** PW) == DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pfq_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [DW-1:0] store [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [PW-1:0] wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   // pointer advance: free wrap for power-of-two depths, explicit compare otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign not_empty = (count != '0);
   assign full      = (count == CNT_W'(DEPTH));
   assign head      = store[rd_ptr];
   assign do_push   = push && !flush;
   assign do_pop    = pop && not_empty && !flush;

   always_ff @(posedge clk) begin
      if (do_push) begin
         store[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R5: a push never lands on a full queue unless a pop frees a slot
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
      (push && !flush && full) |-> do_pop);

   // R7: a flush leaves the queue empty
   a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
      flush |=> (count == '0));

   // R9: simultaneous push and pop keep the occupancy
   a_r9_pushpop_hold: assert property (@(posedge clk) disable iff (rst)
      (do_push && do_pop) |=> (count == $past(count)));

endmodule

// File: rtl/pfq_seq.sv
module pfq_seq
   import pfq_pkg::*;
#(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter logic [SEG_W-1:0] RST_SEG = '0,
   parameter logic [OFF_W-1:0] RST_IP  = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             jmp_vld,
   input  logic [SEG_W-1:0] jmp_seg,
   input  logic [OFF_W-1:0] jmp_off,
   input  logic             rvalid,
   input  logic             q_full,
   output logic             issue,
   output logic             push,
   output logic [SEG_W-1:0] seg_q,
   output logic [OFF_W-1:0] ip_q
);

   fetch_st_t st_q, st_d;

   assign issue = (st_q == ST_IDLE) && !jmp_vld && !q_full && !rst;
   assign push  = (st_q == ST_WAIT) && rvalid && !jmp_vld;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (issue) st_d = ST_WAIT;
         ST_WAIT: begin
            if (rvalid)       st_d = ST_IDLE;
            else if (jmp_vld) st_d = ST_DROP;   // R8: keep waiting, mark stale
         end
         ST_DROP: if (rvalid) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_IDLE;
         seg_q <= RST_SEG;
         ip_q  <= RST_IP;
      end else begin
         st_q <= st_d;
         if (jmp_vld) begin
            seg_q <= jmp_seg;
            ip_q  <= jmp_off;
         end else if (issue) begin
            ip_q  <= ip_q + 1'b1;   // wraps inside the segment (R11)
         end
      end
   end

   // R2: pointer steps by one after each issued fetch
   a_r2_ip_step: assert property (@(posedge clk) disable iff (rst)
      issue |=> (ip_q == OFF_W'($past(ip_q) + 1'b1)));

   // R8: a stale reply is never written to the queue
   a_r8_stale_dropped: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_DROP) |-> !push);

endmodule

// File: rtl/pfq_unit.sv
module pfq_unit #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 6,
   parameter logic [SEG_W-1:0] RST_SEG = 16'hF000,
   parameter logic [OFF_W-1:0] RST_IP  = 16'hFFF0,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              jmp_vld,
   input  logic [SEG_W-1:0]  jmp_seg,
   input  logic [OFF_W-1:0]  jmp_off,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              q_pop,
   output logic              q_vld,
   output logic [DATA_W-1:0] q_byte,
   output logic [CNT_W-1:0]  q_count
);

   logic             f_full, f_nempty, s_push;
   logic [SEG_W-1:0] seg_q;
   logic [OFF_W-1:0] ip_q;

   pfq_seq #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .RST_SEG(RST_SEG), .RST_IP(RST_IP)
   ) u_seq (
      .clk(clk), .rst(rst),
      .jmp_vld(jmp_vld), .jmp_seg(jmp_seg), .jmp_off(jmp_off),
      .rvalid(mem_rvalid), .q_full(f_full),
      .issue(mem_req), .push(s_push),
      .seg_q(seg_q), .ip_q(ip_q)
   );

   pfq_addr #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
   ) u_addr (
      .seg(seg_q), .off(ip_q), .addr(mem_addr)
   );

   pfq_fifo #(
      .DW(DATA_W), .DEPTH(DEPTH)
   ) u_fifo (
      .clk(clk), .rst(rst), .flush(jmp_vld),
      .push(s_push), .din(mem_rdata),
      .pop(q_pop && q_vld),
      .head(q_byte), .not_empty(f_nempty), .full(f_full), .count(q_count)
   );

   assign q_vld = f_nempty && !jmp_vld;

   // port-side tracking of fetches in flight, for the checks below
   logic inflight;
   always_ff @(posedge clk) begin
      if (rst)             inflight <= 1'b0;
      else if (mem_req)    inflight <= 1'b1;
      else if (mem_rvalid) inflight <= 1'b0;
   end

   // R6: never a second request while one is outstanding
   a_r6_one_outstanding: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !inflight);

   // R1: address is segment times sixteen plus pointer, modulo the address space
   a_r1_addr_form: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> (mem_addr ==
         ADDR_W'((ADDR_W + 1)'(seg_q) * (ADDR_W + 1)'(2 ** SHIFT) + (ADDR_W + 1)'(ip_q))));

   // R4: a byte written into an empty queue is offered next cycle
   a_r4_empty_visible: assert property (@(posedge clk) disable iff (rst)
      (s_push && q_count == '0) |=> (q_vld || jmp_vld));

endmodule

// File: tb/sim_pfq_unit.sv
module sim_pfq_unit;

   localparam int DEPTH = 6;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        jmp_vld = 1'b0;
   logic [15:0] jmp_seg = '0, jmp_off = '0;
   logic        mem_req;
   logic [19:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        q_pop = 1'b0;
   logic        q_vld;
   logic [7:0]  q_byte;
   logic [CNT_W-1:0] q_count;

   always #4 clk = ~clk;   // 125 MHz

   pfq_unit #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst(rst),
      .jmp_vld(jmp_vld), .jmp_seg(jmp_seg), .jmp_off(jmp_off),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .q_pop(q_pop), .q_vld(q_vld), .q_byte(q_byte), .q_count(q_count)
   );

   int n_chk = 0, n_fail = 0, n_both = 0;
   bit done = 0;
   logic [7:0] sb[$];             // scoreboard of expected queue contents
   logic [15:0] b_seg = 16'hF000, b_ip = 16'hFFF0;
   bit  pend = 0, stale = 0, push_empty = 0;
   int  lat_left = 0, lat_max = 1, pop_pct = 100, jmp_pct = 0;
   logic [19:0] pend_addr = '0;

   function automatic logic [7:0] mem_byte(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cycle(input bit do_jmp, input logic [15:0] js, input logic [15:0] jo);
      int  cnt_before;
      bit  drive_rv, exp_req, popped;
      logic [19:0] ea;
      @(negedge clk);
      cnt_before = sb.size();
      chk(int'(q_count) == cnt_before, "R8 R9 occupancy", 32'(q_count), 32'(cnt_before));
      if (push_empty && !do_jmp)
         chk(q_vld == 1'b1, "R4 empty-queue byte offered", 32'(q_vld), 1);
      push_empty = 0;
      // drive inputs for the coming edge
      rst = 1'b0;
      jmp_vld = do_jmp; jmp_seg = js; jmp_off = jo;
      drive_rv = 0;
      if (pend) begin
         lat_left--;
         if (lat_left == 0) drive_rv = 1;
      end
      mem_rvalid = drive_rv;
      mem_rdata  = drive_rv ? mem_byte(pend_addr) : 8'h00;
      q_pop = ($urandom_range(99) < pop_pct);
      #1;
      // R7: no byte offered in a jump cycle
      if (do_jmp) chk(q_vld == 1'b0, "R7 no offer in jump cycle", 32'(q_vld), 0);
      popped = 0;
      if (q_pop && q_vld) begin
         chk(sb.size() > 0 && q_byte == sb[0], "R3 byte order",
             32'(q_byte), sb.size() > 0 ? 32'(sb[0]) : 32'hFFFF);
         if (sb.size() > 0) void'(sb.pop_front());
         popped = 1;
      end
      exp_req = !pend && !do_jmp && (cnt_before < DEPTH);
      chk(mem_req == exp_req, "R5 R6 fetch issue", 32'(mem_req), 32'(exp_req));
      if (do_jmp) begin
         sb.delete();
         if (pend) stale = 1;
         b_seg = js; b_ip = jo;
      end
      if (drive_rv) begin
         pend = 0;
         if (!stale && !do_jmp) begin
            if (popped) n_both++;
            sb.push_back(mem_byte(pend_addr));
            if (cnt_before == 0) push_empty = 1;
         end
         stale = 0;
      end
      if (mem_req) begin
         ea = {b_seg, 4'h0} + {4'h0, b_ip};
         chk(mem_addr == ea, "R1 R2 R11 fetch address", 32'(mem_addr), 32'(ea));
         b_ip = b_ip + 16'd1;
         pend = 1;
         lat_left = $urandom_range(lat_max, 1);
         pend_addr = mem_addr;
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         if ($urandom_range(99) < jmp_pct)
            cycle(1, 16'($urandom), 16'($urandom));
         else
            cycle(0, 16'h0, 16'h0);
      end
   endtask

   initial begin
      void'($urandom(7));
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(q_vld == 1'b0, "R10 reset queue empty", 32'(q_vld), 0);
      chk(q_count == '0, "R10 reset count", 32'(q_count), 0);
      chk(mem_req == 1'b0, "R10 no fetch in reset", 32'(mem_req), 0);
      // first cycle out of reset: fetch at reset segment:pointer
      cycle(0, 16'h0, 16'h0);
      chk(pend_addr == 20'hFFFF0, "R10 first fetch address", 32'(pend_addr), 32'hFFFF0);

      // fast memory, eager consumer
      lat_max = 1; pop_pct = 100; run(200);
      // stalled consumer: queue fills to DEPTH and fetching stops
      lat_max = 3; pop_pct = 0; run(60);
      chk(q_count == CNT_W'(DEPTH), "R5 queue full", 32'(q_count), DEPTH);
      pop_pct = 100; run(40);
      // pointer and address wrap
      cycle(1, 16'hFFFF, 16'hFFFE);
      pop_pct = 60; lat_max = 2; run(40);
      // jump exactly when a reply is due
      for (int k = 0; k < 20; k++) begin
         while (!(pend && lat_left == 1)) cycle(0, 16'h0, 16'h0);
         cycle(1, 16'(16'h1000 + k), 16'(16'h0100 * k));
         run(5);
      end
      // jump while a slow reply is still pending (R8)
      lat_max = 4;
      for (int k = 0; k < 20; k++) begin
         while (!(pend && lat_left >= 3)) cycle(0, 16'h0, 16'h0);
         cycle(1, 16'(16'h2000 + k), 16'(16'hFFF0 + k));
         run(6);
      end
      // mixed traffic with random jumps
      pop_pct = 50; jmp_pct = 3; run(3000);
      jmp_pct = 0; pop_pct = 100; run(30);
      chk(n_both > 0, "R9 push and pop in one cycle seen", 32'(n_both), 1);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule